// File: doc/BRIEF.md
# Quadrature Direct Digital Synthesizer

This block generates a sampled sine wave and a matching cosine wave, one new pair on every clock. A frequency word is added into a phase register each cycle, and the running phase selects the amplitude pair. The output frequency is therefore the sample clock times the frequency word divided by 512. At a 1 GHz clock one unit of the word is about 1.95 MHz.

Both waves come from a single table of quarter-wave sine magnitudes. The table has two read ports. The cosine is read as the sine a quarter turn ahead. The sign is applied after the table read, so the stored table is a fraction of a full cycle. A new frequency word shows up at the outputs with a fixed two-cycle latency, and the two outputs always describe the same phase sample.

Top module: `ddfs_quad`

## Requirements
- R1: The phase register is 9 bits wide. Out of reset, each clock adds the 9-bit frequency word to it modulo 512, with no overflow flag, so a phase of 512 wraps to 0.
- R2: The sine output is an 8-bit two's-complement word whose value is round(127·sin(2π·p/512)) for phase p, with at most one LSB of error. At p = 0, 128, 256 and 384 the value is exactly 0, 127, 0 and -127.
- R3: The cosine output in the same cycle equals the sine value for phase p+128 (mod 512), so both outputs are aligned to one phase sample.
- R4: For a phase whose top bit is 1 (p ≥ 256), the sine output is zero or negative, because the sign is applied after the magnitude lookup.
- R5: A frequency word applied on a clock edge first changes the phase at that edge, and the output sampled from that phase appears one edge later: a change of word shows at the outputs two cycles after it is applied.
- R6: While synchronous reset is high, the phase is 0, both outputs are 0 and valid is 0. The first edge after reset is released sets valid to 1 with the sample for phase 0 (sine 0, cosine 127), and valid stays high until the next reset.
- R7: A frequency word of zero holds the phase, so the outputs stay constant.
- R8: Neither output ever takes the value -128. The output range is symmetric at ±127.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| fcw | input | 9 | Frequency word, phase increment per clock |
| sin_out | output | 8 | Signed sine sample |
| cos_out | output | 8 | Signed cosine sample |
| valid | output | 1 | High once registered samples are present |

## Verification
A word of zero shows whether the phase is held rather than drifting. A word of 128 steps through the four exact quadrant points and wraps, which tells apart mistakes in folding, sign and cosine offset that tolerance checks would not catch. Random words with a fixed seed, mixed with held stretches, cover every mirrored address and the two-cycle latency when the word changes. A reset in the middle of a run shows that the phase and valid restart cleanly.

// File: rtl/ddfs_pkg.sv
package ddfs_pkg;

    // Quadrant of the phase, from its two top bits
    typedef enum logic [1:0] {
        Q_RISE  = 2'd0,
        Q_FALL  = 2'd1,
        Q_NRISE = 2'd2,
        Q_NFALL = 2'd3
    } quad_e;

    // Per-port lookup request: mirrored table address and sign
    typedef struct packed {
        logic [15:0] addr;
        logic        neg;
    } fold_t;

    // Second and fourth quadrants read the table backwards
    function automatic logic quad_mirror(quad_e q);
        return (q == Q_FALL) || (q == Q_NFALL);
    endfunction

    // Second half of the turn carries a negative sine
    function automatic logic quad_negate(quad_e q);
        return (q == Q_NRISE) || (q == Q_NFALL);
    endfunction

    // Rational sine approximation on the half turn, scaled to full range
    // k: step within a half turn of 2^(pw-1) steps (0 .. 2^(pw-2))
    function automatic int qsin_mag(int k, int pw, int aw);
        longint half;
        longint u;
        longint amp;
        longint num;
        longint den;
        half = longint'(1) << (pw - 1);
        amp  = (longint'(1) << (aw - 1)) - 1;
        u    = longint'(k) * (half - longint'(k));
        num  = 16 * u * amp;
        den  = 5 * half * half - 4 * u;
        return int'((2 * num + den) / (2 * den));
    endfunction

endpackage

// File: rtl/ddfs_phase_acc.sv
module ddfs_phase_acc #(
    parameter int PW = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [PW-1:0] fcw,
    output logic [PW-1:0] phase
);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= '0;
        end else begin
            phase <= phase + fcw;
        end
    end

    AST_ZERO_FCW_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && ($past(fcw) == '0)) |-> (phase == $past(phase))); // R7

endmodule

// File: rtl/ddfs_fold.sv
module ddfs_fold #(
    parameter int PW = 9
) (
    input  logic [PW-1:0] phase,
    output logic [PW-2:0] addr,
    output logic          neg
);
    import ddfs_pkg::*;

    localparam int IW = PW - 2;
    localparam logic [PW-2:0] QSTEPS = (PW-1)'(1) << IW;

    quad_e          quad;
    logic [IW-1:0]  idx;

    always_comb begin
        quad = quad_e'(phase[PW-1:PW-2]);
        idx  = phase[IW-1:0];
        if (quad_mirror(quad)) begin
            addr = QSTEPS - {1'b0, idx};
        end else begin
            addr = {1'b0, idx};
        end
        neg = quad_negate(quad);
    end

endmodule

// File: rtl/ddfs_qrom.sv
module ddfs_qrom #(
    parameter int PW = 9,
    parameter int AW = 8
) (
    input  logic [PW-2:0] addr_a,
    input  logic [PW-2:0] addr_b,
    output logic [AW-2:0] mag_a,
    output logic [AW-2:0] mag_b
);
    localparam int DEPTH = (1 << (PW - 2)) + 1;

    logic [AW-2:0] tbl [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        assign tbl[g] = (AW-1)'(ddfs_pkg::qsin_mag(g, PW, AW));
    end

    always_comb begin
        mag_a = (int'(addr_a) < DEPTH) ? tbl[addr_a] : '0;
        mag_b = (int'(addr_b) < DEPTH) ? tbl[addr_b] : '0;
    end

endmodule

// File: rtl/ddfs_quad.sv
module ddfs_quad #(
    parameter int PW = 9,
    parameter int AW = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [PW-1:0]        fcw,
    output logic signed [AW-1:0] sin_out,
    output logic signed [AW-1:0] cos_out,
    output logic                 valid
);
    import ddfs_pkg::*;

    localparam logic [PW-1:0] QTURN = PW'(1) << (PW - 2);
    localparam logic signed [AW-1:0] AMP  = AW'((1 << (AW - 1)) - 1);
    localparam logic signed [AW-1:0] MINF = AW'(1 << (AW - 1));

    logic [PW-1:0] phase;
    logic [PW-1:0] cphase;
    fold_t         req [2];
    logic [PW-2:0] addr [2];
    logic          neg  [2];
    logic [AW-2:0] mag  [2];
    logic signed [AW-1:0] smp [2];

    ddfs_phase_acc #(.PW(PW)) u_acc (
        .clk   (clk),
        .rst   (rst),
        .fcw   (fcw),
        .phase (phase)
    );

    assign cphase = phase + QTURN;

    for (genvar p = 0; p < 2; p++) begin : g_port
        ddfs_fold #(.PW(PW)) u_fold (
            .phase ((p == 0) ? phase : cphase),
            .addr  (addr[p]),
            .neg   (neg[p])
        );
        always_comb begin
            req[p].addr = 16'(addr[p]);
            req[p].neg  = neg[p];
            if (req[p].neg) begin
                smp[p] = -$signed({1'b0, mag[p]});
            end else begin
                smp[p] = $signed({1'b0, mag[p]});
            end
        end
    end

    ddfs_qrom #(.PW(PW), .AW(AW)) u_rom (
        .addr_a (req[0].addr[PW-2:0]),
        .addr_b (req[1].addr[PW-2:0]),
        .mag_a  (mag[0]),
        .mag_b  (mag[1])
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sin_out <= '0;
            cos_out <= '0;
            valid   <= 1'b0;
        end else begin
            sin_out <= smp[0];
            cos_out <= smp[1];
            valid   <= 1'b1;
        end
    end

    AST_ZERO_PHASE_PAIR: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && ($past(phase) == '0)) |-> (sin_out == '0 && cos_out == AMP)); // R3
    AST_LOWER_HALF_SIGN: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(phase[PW-1])) |-> (sin_out <= 0)); // R4
    AST_NO_MINUS_FULL: assert property (@(posedge clk) disable iff (rst)
        valid |-> (sin_out != MINF && cos_out != MINF)); // R8
    AST_VALID_LATE: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !valid); // R6
    AST_VALID_STAYS: assert property (@(posedge clk) disable iff (rst)
        valid |=> valid); // R6

endmodule

// File: tb/sim_ddfs_quad.sv
`timescale 1ns/1ps
module sim_ddfs_quad;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [8:0]       fcw = '0;
    logic signed [7:0] sin_out;
    logic signed [7:0] cos_out;
    logic             valid;

    int checks = 0;
    int errors = 0;
    int m_acc  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    ddfs_quad u0 (
        .clk     (clk),
        .rst     (rst),
        .fcw     (fcw),
        .sin_out (sin_out),
        .cos_out (cos_out),
        .valid   (valid)
    );

    function automatic int ref_sin(int p);
        real x;
        x = 127.0 * $sin(2.0 * 3.14159265358979 * real'(p % 512) / 512.0);
        return (x >= 0.0) ? $rtoi(x + 0.5) : -$rtoi(-x + 0.5);
    endfunction

    function automatic int iabs(int v);
        return (v < 0) ? -v : v;
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_amp(string req, int act, int p);
        int e;
        e = ref_sin(p);
        if (p % 128 == 0) chk(act == e, req, act, e);
        else              chk(iabs(act - e) <= 1, req, act, e);
    endtask

    // At a negedge: apply word, advance model, compare after the next edge
    task automatic step(logic [8:0] f, string req);
        int p;
        fcw   = f;
        p     = m_acc;
        m_acc = (m_acc + int'(f)) % 512;
        @(posedge clk);
        @(negedge clk);
        chk(valid == 1'b1, {req, "/R6 valid"}, int'(valid), 1);
        chk_amp({req, "/R2 sine"}, int'(sin_out), p);
        chk_amp({req, "/R3 cosine"}, int'(cos_out), p + 128);
        if (p > 256 && ref_sin(p) < -1)
            chk(sin_out < 0, {req, "/R4 sign"}, int'(sin_out), ref_sin(p));
        chk(sin_out != -128 && cos_out != -128, {req, "/R8 range"}, int'(sin_out), 0);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(valid == 1'b0, "R6 valid in reset", int'(valid), 0);
        chk(sin_out == 0, "R6 sine in reset", int'(sin_out), 0);
        chk(cos_out == 0, "R6 cosine in reset", int'(cos_out), 0);
        rst   = 1'b0;
        m_acc = 0;
    endtask

    initial begin
        #(10ns * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [8:0] prev;
        void'($urandom(32'd2014));
        @(negedge clk);
        do_reset();
        // R6: first sample is phase 0
        step(9'd0, "R6 first sample");
        chk(sin_out == 0 && cos_out == 127, "R6 first pair", int'(cos_out), 127);
        // R7: zero word holds phase
        step(9'd0, "R7 hold");
        step(9'd0, "R7 hold");
        chk(sin_out == 0 && cos_out == 127, "R7 still phase 0", int'(sin_out), 0);
        // R5: word 128 from phase 0, outputs change on the second edge
        step(9'd128, "R5 apply");
        chk(sin_out == 0 && cos_out == 127, "R5 no change yet", int'(sin_out), 0);
        step(9'd128, "R5 quarter");
        chk(sin_out == 127 && cos_out == 0, "R5 quarter point", int'(sin_out), 127);
        step(9'd128, "R2 half");
        chk(sin_out == 0 && cos_out == -127, "R2 half point", int'(cos_out), -127);
        step(9'd128, "R2 three quarter");
        chk(sin_out == -127 && cos_out == 0, "R4 three quarter", int'(sin_out), -127);
        step(9'd5, "R1 wrap");
        chk(sin_out == 0 && cos_out == 127, "R1 wrap to phase 0", int'(cos_out), 127);
        // R1 odd step that wraps irregularly
        for (int i = 0; i < 200; i++) step(9'd511, "R1 backward");
        // random words mixed with held stretches
        prev = 9'd1;
        for (int i = 0; i < 600; i++) begin
            logic [8:0] f;
            f = ($urandom % 5 == 0) ? prev : 9'($urandom);
            if ($urandom % 9 == 0) f = 9'd0;
            step(f, "R2 random");
            prev = f;
        end
        // reset in the middle of a run
        fcw = 9'd77;
        do_reset();
        step(9'd33, "R6 restart");
        chk(sin_out == 0 && cos_out == 127, "R6 restart pair", int'(cos_out), 127);
        for (int i = 0; i < 40; i++) step(9'd33, "R1 after restart");
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule